// File: doc/BRIEF.md
# Sticky Lockdown Mode Controller

This block keeps the lockdown state of two protection domains: the local instruction and data memories (domain 0), and the register space of the crypto coprocessor (domain 1). Software writes a control register to request lockdown. Any requester can enter lockdown. Leaving it is gated by privilege. Only a write made at the top security mode can clear a lock. A clear attempted from a lower mode is not carried out. It is recorded as a pending exit, and that exit completes on the next top-mode write.

Each domain also has a history flag. The flag shows that the domain was locked at some point since reset, and software cannot clear it. A separate override register can release the crypto-domain lock, and only a requester in debug mode can arm it. The per-domain lock outputs feed the access filters of the memories and the coprocessor. Those filters lie outside this block.

Top module: `lockdown_ctrl`

## Requirements
- R1: After a synchronous reset, both register images read 0 and both lock outputs are low.
- R2: A control write (wr_sel=0) with bit 0 or bit 4 set sets the memory or the crypto enable on the next clock edge, at any privilege. Privilege encoding: 0 non-secure, 1 reserved, 2 light secure, 3 top.
- R3: A control write at privilege 3 loads the enable bits 0 and 4 from the written data and clears the pending-exit flag (bit 1).
- R4: A control write below privilege 3 never clears an enable. If it writes 0 to an enable that is set, that enable stays set and the pending-exit flag (bit 1) becomes 1.
- R5: A domain whose exit is pending is unlocked by the next privilege-3 control write, even when that write carries a 1 for it.
- R6: History bit 2 (memory) and bit 6 (crypto) become 1 together with their enable. Writes do not clear them; only reset does. Bits 1, 2 and 6 of written data are ignored.
- R7: Override bit 8 (override register, wr_sel=1) can be set only when dbg_mode is high. A write of 0 clears it in any mode.
- R8: mem_lock equals control bit 0. crypto_lock equals control bit 4 AND NOT override bit 8.
- R9: rd_data shows the control image when rd_sel=0 and the override image when rd_sel=1. All undefined bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 override |
| wr_data | input | 32 | Write data |
| priv | input | 2 | Privilege of the requester (3 = top) |
| dbg_mode | input | 1 | Requester is in debug mode |
| rd_sel | input | 1 | Read target: 0 control, 1 override |
| rd_data | output | 32 | Selected register image |
| mem_lock | output | 1 | Memory domain locked |
| crypto_lock | output | 1 | Crypto register domain locked |

## Verification
Directed sequences cover the main cases. A low-privilege clear attempt is compared against a top-privilege clear, which separates the pending-exit path from a direct exit. A top write that sets a pending domain again shows that the pending exit takes priority. The override is tried with dbg_mode both low and high, and it is cleared outside debug mode. Random writes then mix privileges, targets and debug state, and the images and locks are checked against a bench model after every write. This exposes ordering faults between pending exits, history flags and the override.

// File: rtl/lockdown_pkg.sv
package lockdown_pkg;

    localparam int REG_W    = 32;
    localparam int NUM_DOM  = 2;
    localparam int PEND_POS = 1;
    localparam int OVR_POS  = 8;

    typedef enum logic [1:0] {
        PRV_NONSEC = 2'd0,
        PRV_RSVD   = 2'd1,
        PRV_LIGHT  = 2'd2,
        PRV_TOP    = 2'd3
    } priv_e;

    typedef struct packed {
        logic en;
        logic exit_req;
        logic hist;
    } dom_state_t;

    function automatic int en_pos(input int dom);
        return (dom == 0) ? 0 : 4;
    endfunction

    function automatic int hist_pos(input int dom);
        return (dom == 0) ? 2 : 6;
    endfunction

endpackage

// File: rtl/lockdown_domain.sv
module lockdown_domain
    import lockdown_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctl,
    input  logic       top_priv,
    input  logic       wr_bit,
    output dom_state_t st
);

    logic en_next;
    logic req_next;

    always_comb begin
        en_next  = st.en;
        req_next = st.exit_req;
        if (wr_ctl) begin
            if (top_priv) begin
                en_next  = wr_bit & ~st.exit_req;
                req_next = 1'b0;
            end else begin
                en_next  = st.en | wr_bit;
                req_next = st.exit_req | (st.en & ~wr_bit);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.en       <= en_next;
            st.exit_req <= req_next;
            st.hist     <= st.hist | en_next;
        end
    end

    p_hist_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        st.hist |=> st.hist);
    p_hist_follow_r6: assert property (@(posedge clk) disable iff (rst)
        st.en |-> st.hist);
    p_low_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !top_priv && st.en) |=> st.en);
    p_low_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && !top_priv && st.en && !wr_bit) |=> st.exit_req);
    p_exit_done_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && top_priv && st.exit_req) |=> !st.en);

endmodule

// File: rtl/lockdown_override.sv
module lockdown_override (
    input  logic clk,
    input  logic rst,
    input  logic wr_ovr,
    input  logic dbg,
    input  logic wr_bit,
    output logic ovr
);

    always_ff @(posedge clk) begin
        if (rst)
            ovr <= 1'b0;
        else if (wr_ovr)
            ovr <= dbg ? wr_bit : (ovr & wr_bit);
    end

    p_ovr_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (!ovr && !(wr_ovr && dbg)) |=> !ovr);

endmodule

// File: rtl/lockdown_ctrl.sv
module lockdown_ctrl
    import lockdown_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       priv,
    input  logic             dbg_mode,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             mem_lock,
    output logic             crypto_lock
);

    dom_state_t       st [NUM_DOM];
    logic             wr_ctl;
    logic             top_priv;
    logic             pending;
    logic             ovr;
    logic [REG_W-1:0] ctl_img;
    logic [REG_W-1:0] ovr_img;

    assign wr_ctl   = wr_en & ~wr_sel;
    assign top_priv = (priv_e'(priv) == PRV_TOP);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        localparam int EP = en_pos(d);
        lockdown_domain u_dom (
            .clk      (clk),
            .rst      (rst),
            .wr_ctl   (wr_ctl),
            .top_priv (top_priv),
            .wr_bit   (wr_data[EP]),
            .st       (st[d])
        );
    end

    lockdown_override u_ovr (
        .clk    (clk),
        .rst    (rst),
        .wr_ovr (wr_en & wr_sel),
        .dbg    (dbg_mode),
        .wr_bit (wr_data[OVR_POS]),
        .ovr    (ovr)
    );

    always_comb begin
        pending = 1'b0;
        ctl_img = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            pending              = pending | st[d].exit_req;
            ctl_img[en_pos(d)]   = st[d].en;
            ctl_img[hist_pos(d)] = st[d].hist;
        end
        ctl_img[PEND_POS] = pending;
        ovr_img           = '0;
        ovr_img[OVR_POS]  = ovr;
    end

    assign rd_data     = rd_sel ? ovr_img : ctl_img;
    assign mem_lock    = st[0].en;
    assign crypto_lock = st[1].en & ~ovr;

    p_pend_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && top_priv) |=> !pending);
    p_lock_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        ovr |-> !crypto_lock);
    p_set_free_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && wr_data[0] && !(top_priv && st[0].exit_req)) |=> mem_lock);

endmodule

// File: tb/tb_lockdown_ctrl.sv
module tb_lockdown_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_sel, dbg_mode, rd_sel;
    logic [31:0] wr_data;
    logic [1:0]  priv;
    logic [31:0] rd_data;
    logic        mem_lock, crypto_lock;

    int n_chk = 0;
    int n_fail = 0;

    logic m_en [2];
    logic m_req [2];
    logic m_hist [2];
    logic m_ovr;

    always #4 clk = ~clk;

    lockdown_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .priv(priv), .dbg_mode(dbg_mode),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .mem_lock(mem_lock), .crypto_lock(crypto_lock)
    );

    function automatic logic [31:0] exp_ctl();
        logic [31:0] v = '0;
        v[0] = m_en[0];
        v[4] = m_en[1];
        v[2] = m_hist[0];
        v[6] = m_hist[1];
        v[1] = m_req[0] | m_req[1];
        return v;
    endfunction

    function automatic logic [31:0] exp_ovr();
        logic [31:0] v = '0;
        v[8] = m_ovr;
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model_write(input logic s, input logic [31:0] d,
                               input logic [1:0] p, input logic g);
        if (!s) begin
            for (int k = 0; k < 2; k++) begin
                logic b = d[k == 0 ? 0 : 4];
                if (p == 2'd3) begin
                    m_en[k]  = b & ~m_req[k];
                    m_req[k] = 1'b0;
                end else begin
                    m_req[k] = m_req[k] | (m_en[k] & ~b);
                    m_en[k]  = m_en[k] | b;
                end
                m_hist[k] = m_hist[k] | m_en[k];
            end
        end else begin
            m_ovr = g ? d[8] : (m_ovr & d[8]);
        end
    endtask

    task automatic compare_all(input string tag);
        rd_sel = 1'b0;
        #1 check({tag, " R9 control image"}, rd_data, exp_ctl());
        rd_sel = 1'b1;
        #1 check({tag, " R9 override image"}, rd_data, exp_ovr());
        check({tag, " R8 mem_lock"}, {31'b0, mem_lock}, {31'b0, m_en[0]});
        check({tag, " R8 crypto_lock"}, {31'b0, crypto_lock}, {31'b0, m_en[1] & ~m_ovr});
    endtask

    task automatic do_write(input logic s, input logic [31:0] d,
                            input logic [1:0] p, input logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d; priv = p; dbg_mode = g;
        @(posedge clk);
        #1 wr_en = 1'b0;
        model_write(s, d, p, g);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(77);
        rst = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        priv = 2'd0; dbg_mode = 1'b0; rd_sel = 1'b0;
        for (int k = 0; k < 2; k++) begin m_en[k] = 0; m_req[k] = 0; m_hist[k] = 0; end
        m_ovr = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        compare_all("R1 reset");

        do_write(1'b0, 32'h0000_0011, 2'd0, 1'b0);
        compare_all("R2 set both at nonsecure");
        check("R6 history set", rd_data & 32'h0, 32'h0);
        rd_sel = 1'b0;
        #1 check("R6 history bits 2 and 6", rd_data & 32'h44, 32'h44);

        do_write(1'b0, 32'h0000_0010, 2'd2, 1'b0);
        compare_all("R4 low clear attempt");
        rd_sel = 1'b0;
        #1 check("R4 mem stays, pending set", rd_data & 32'h3, 32'h3);

        do_write(1'b0, 32'h0000_0011, 2'd3, 1'b0);
        compare_all("R5 pending exit honoured");
        rd_sel = 1'b0;
        #1 check("R5 mem unlocked despite 1", {31'b0, mem_lock}, 32'h0);
        check("R3 pending cleared", rd_data & 32'h2, 32'h0);

        do_write(1'b0, 32'h0000_0046, 2'd3, 1'b0);
        compare_all("R3 top clear all");
        rd_sel = 1'b0;
        #1 check("R6 history kept after clear", rd_data, 32'h44);

        do_write(1'b1, 32'h0000_0100, 2'd3, 1'b0);
        do_write(1'b0, 32'h0000_0010, 2'd3, 1'b0);
        compare_all("R7 no set outside debug");
        do_write(1'b1, 32'h0000_0100, 2'd0, 1'b1);
        compare_all("R7 set in debug");
        check("R8 override defeats lock", {31'b0, crypto_lock}, 32'h0);
        do_write(1'b1, 32'h0000_0000, 2'd0, 1'b0);
        compare_all("R7 clear outside debug");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] d = $urandom;
            logic [1:0]  p = ($urandom % 4 == 0) ? 2'd3 : 2'($urandom);
            logic        s = ($urandom % 5 == 0);
            logic        g = ($urandom % 3 == 0);
            do_write(s, d, p, g);
            compare_all("R2-random");
        end

        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 2; k++) begin m_en[k] = 0; m_req[k] = 0; m_hist[k] = 0; end
        m_ovr = 1'b0;
        compare_all("R1 second reset");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule